// File: doc/BRIEF.md
# Integer Execution Unit with Barrel Shifter

This block is the integer execution stage of a 32-bit load/store processor core. Each cycle it takes an operation code, two operands and a 5-bit shift count. It registers the result of the selected operation and an overflow-trap flag, and these appear on its outputs one clock later. The operations are:

- Add and subtract, each with and without overflow detection.
- Set-on-less-than, in signed and unsigned forms.
- The four bitwise operations.
- Load-upper-immediate.
- Left and right shifts, logical and arithmetic. The count comes either from the fixed shift-count input or from the low bits of the first operand.

Any sign or zero extension of an immediate is done before the operand reaches this block. When the trap flag rises, the result is still driven. The surrounding core uses the flag alone to cancel the register write.

Operation codes (5 bits):

| Code | Operation |
|------|-----------|
| 0 | ADD |
| 1 | ADDU |
| 2 | SUB |
| 3 | SUBU |
| 4 | SLT |
| 5 | SLTU |
| 6 | AND |
| 7 | OR |
| 8 | XOR |
| 9 | NOR |
| 10 | LUI |
| 11 | SLL |
| 12 | SRL |
| 13 | SRA |
| 14 | SLLV |
| 15 | SRLV |
| 16 | SRAV |
| 17 to 31 | unused |

In every shift, the value being shifted is operand B.

Top module: `int_exec_alu`

## Requirements
- R1: While reset is high, the result becomes 0 and the trap flag becomes 0 at the next clock edge.
- R2: For ADD (code 0), the result is A+B mod 2^32. For SUB (code 2), the result is A-B mod 2^32. For both codes the trap flag is 1 exactly when the two's-complement result overflows.
- R3: ADDU (code 1) and SUBU (code 3) give the same result as ADD and SUB, and their trap flag is always 0.
- R4: SLT (code 4, signed) and SLTU (code 5, unsigned) produce exactly 1 when A < B and 0 otherwise.
- R5: AND, OR, XOR and NOR (codes 6 to 9) produce the bitwise function of A and B.
- R6: LUI (code 10) places B[15:0] in result bits 31:16 and sets bits 15:0 to zero.
- R7: SLL (code 11) and SRL (code 12) shift B by the shift-count input and fill the vacated bits with zeros.
- R8: SRA (code 13) shifts B right by the shift-count input and fills with B[31]; for example, 0xFFFFFFFB shifted by 1 gives 0xFFFFFFFD.
- R9: SLLV, SRLV and SRAV (codes 14 to 16) shift B by A[4:0] only. A[31:5] and the shift-count input have no effect.
- R10: Codes 17 to 31 produce result 0 with the trap flag at 0.
- R11: The outputs reflect the inputs present at the previous rising clock edge and stay unchanged between edges.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| op_i | input | 5 | Operation code |
| a_i | input | 32 | First operand (source of the variable shift count) |
| b_i | input | 32 | Second operand (value that is shifted, source of the LUI immediate) |
| shamt_i | input | 5 | Fixed shift count |
| result_o | output | 32 | Registered result |
| trap_o | output | 1 | Registered overflow-trap flag |

## Verification
The hardest conditions to reach are the exact overflow boundaries. Examples are 0x7FFFFFFF+1, 0x80000000-1, and 0x80000000 compared with 0x7FFFFFFF, where the signed and unsigned orderings disagree. Random operands almost never land on these points. The sweep therefore crosses a fixed set of boundary operands with every code. For the variable shifts, the same set is applied with A values whose upper bits are non-zero and with the fixed-count input set to a different value, so that a count taken from the wrong source or from too many bits shows up in the result.

// File: rtl/int_exec_alu_pkg.sv
package int_exec_alu_pkg;
  localparam int OP_W = 5;

  typedef enum logic [OP_W-1:0] {
    OP_ADD  = 5'd0,
    OP_ADDU = 5'd1,
    OP_SUB  = 5'd2,
    OP_SUBU = 5'd3,
    OP_SLT  = 5'd4,
    OP_SLTU = 5'd5,
    OP_AND  = 5'd6,
    OP_OR   = 5'd7,
    OP_XOR  = 5'd8,
    OP_NOR  = 5'd9,
    OP_LUI  = 5'd10,
    OP_SLL  = 5'd11,
    OP_SRL  = 5'd12,
    OP_SRA  = 5'd13,
    OP_SLLV = 5'd14,
    OP_SRLV = 5'd15,
    OP_SRAV = 5'd16
  } alu_op_e;
endpackage

// File: rtl/alu_addsub.sv
module alu_addsub #(
  parameter int W = 32
) (
  input  logic [W-1:0] a,
  input  logic [W-1:0] b,
  input  logic         sub,
  output logic [W-1:0] sum,
  output logic         ovf,
  output logic         lt_s,
  output logic         lt_u
);
  logic [W-1:0] b_eff;
  logic         carry;

  assign b_eff        = sub ? ~b : b;
  assign {carry, sum} = {1'b0, a} + {1'b0, b_eff} + {{W{1'b0}}, sub};
  assign ovf          = (a[W-1] == b_eff[W-1]) && (sum[W-1] != a[W-1]);
  assign lt_s         = sum[W-1] ^ ovf;
  assign lt_u         = ~carry;
endmodule

// File: rtl/alu_logic.sv
module alu_logic #(
  parameter int W = 32
) (
  input  logic [W-1:0] a,
  input  logic [W-1:0] b,
  input  logic [1:0]   fn,
  output logic [W-1:0] y
);
  always_comb begin
    case (fn)
      2'd0:    y = a & b;
      2'd1:    y = a | b;
      2'd2:    y = a ^ b;
      default: y = ~(a | b);
    endcase
  end
endmodule

// File: rtl/alu_shifter.sv
module alu_shifter #(
  parameter int W   = 32,
  parameter int SHW = $clog2(W)
) (
  input  logic [W-1:0]   val,
  input  logic [SHW-1:0] cnt,
  input  logic           left,
  input  logic           arith,
  output logic [W-1:0]   y
);
  function automatic logic [W-1:0] rev(input logic [W-1:0] v);
    logic [W-1:0] r;
    for (int i = 0; i < W; i++) r[i] = v[W-1-i];
    return r;
  endfunction

  logic [W-1:0] stg [SHW+1];
  logic         fill;

  assign fill   = arith & ~left & val[W-1];
  assign stg[0] = left ? rev(val) : val;

  for (genvar k = 0; k < SHW; k++) begin : g_stage
    localparam int S = 1 << k;
    assign stg[k+1] = cnt[k] ? {{S{fill}}, stg[k][W-1:S]} : stg[k];
  end

  assign y = left ? rev(stg[SHW]) : stg[SHW];
endmodule

// File: rtl/int_exec_alu.sv
module int_exec_alu
  import int_exec_alu_pkg::*;
#(
  parameter int W    = 32,
  parameter int SHW  = $clog2(W),
  parameter int HALF = W / 2
) (
  input  logic            clk,
  input  logic            rst,
  input  logic [OP_W-1:0] op_i,
  input  logic [W-1:0]    a_i,
  input  logic [W-1:0]    b_i,
  input  logic [SHW-1:0]  shamt_i,
  output logic [W-1:0]    result_o,
  output logic            trap_o
);
  alu_op_e op;
  assign op = alu_op_e'(op_i);

  logic         do_sub, ovf, lt_s, lt_u;
  logic [W-1:0] sum, log_y, sh_y;
  logic [1:0]   log_fn;
  logic [SHW-1:0] sh_cnt;
  logic         sh_left, sh_arith, var_sh;

  assign do_sub = (op == OP_SUB) || (op == OP_SUBU) || (op == OP_SLT) || (op == OP_SLTU);

  alu_addsub #(.W(W)) u_addsub (
    .a(a_i), .b(b_i), .sub(do_sub),
    .sum(sum), .ovf(ovf), .lt_s(lt_s), .lt_u(lt_u)
  );

  assign log_fn = op_i[1:0] - 2'd2;

  alu_logic #(.W(W)) u_logic (
    .a(a_i), .b(b_i), .fn(log_fn), .y(log_y)
  );

  assign var_sh   = (op == OP_SLLV) || (op == OP_SRLV) || (op == OP_SRAV);
  assign sh_cnt   = var_sh ? a_i[SHW-1:0] : shamt_i;
  assign sh_left  = (op == OP_SLL) || (op == OP_SLLV);
  assign sh_arith = (op == OP_SRA) || (op == OP_SRAV);

  alu_shifter #(.W(W), .SHW(SHW)) u_shift (
    .val(b_i), .cnt(sh_cnt), .left(sh_left), .arith(sh_arith), .y(sh_y)
  );

  logic [W-1:0] res_d;
  logic         trap_d;

  always_comb begin
    res_d  = '0;
    trap_d = 1'b0;
    case (op)
      OP_ADD, OP_SUB:   begin res_d = sum; trap_d = ovf; end
      OP_ADDU, OP_SUBU: res_d = sum;
      OP_SLT:           res_d = {{(W-1){1'b0}}, lt_s};
      OP_SLTU:          res_d = {{(W-1){1'b0}}, lt_u};
      OP_AND, OP_OR, OP_XOR, OP_NOR: res_d = log_y;
      OP_LUI:           res_d = {b_i[HALF-1:0], {HALF{1'b0}}};
      OP_SLL, OP_SRL, OP_SRA, OP_SLLV, OP_SRLV, OP_SRAV: res_d = sh_y;
      default:          res_d = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      result_o <= '0;
      trap_o   <= 1'b0;
    end else begin
      result_o <= res_d;
      trap_o   <= trap_d;
    end
  end

  // R1
  reset_clear_chk: assert property (@(posedge clk) rst |=> (result_o == '0 && !trap_o));

  // R3
  no_overflow_chk: assert property (@(posedge clk) disable iff (rst)
    ($past(op_i) != OP_ADD && $past(op_i) != OP_SUB && !$past(rst)) |-> !trap_o);

  // R4
  slt_bool_chk: assert property (@(posedge clk) disable iff (rst)
    (($past(op_i) == OP_SLT || $past(op_i) == OP_SLTU) && !$past(rst)) |-> (result_o[W-1:1] == '0));

  // R6
  lui_low_zero_chk: assert property (@(posedge clk) disable iff (rst)
    ($past(op_i) == OP_LUI && !$past(rst)) |-> (result_o[HALF-1:0] == '0));

  // R10
  unused_zero_chk: assert property (@(posedge clk) disable iff (rst)
    ($past(op_i) > OP_SRAV && !$past(rst)) |-> (result_o == '0 && !trap_o));
endmodule

// File: tb/int_exec_alu_bench.sv
module int_exec_alu_bench;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [4:0]  op_i = '0;
  logic [31:0] a_i = '0, b_i = '0;
  logic [4:0]  shamt_i = '0;
  logic [31:0] result_o;
  logic        trap_o;

  int vectors = 0;
  int errors  = 0;

  always #4 clk = ~clk;

  int_exec_alu u_int_exec_alu (
    .clk(clk), .rst(rst), .op_i(op_i), .a_i(a_i), .b_i(b_i),
    .shamt_i(shamt_i), .result_o(result_o), .trap_o(trap_o)
  );

  function automatic logic [31:0] pat(input int i);
    case (i)
      0: return 32'h0000_0000;   1: return 32'h0000_0001;
      2: return 32'h0000_0002;   3: return 32'h0000_0005;
      4: return 32'h7FFF_FFFF;   5: return 32'h8000_0000;
      6: return 32'hFFFF_FFFF;   7: return 32'hFFFF_FFFB;
      8: return 32'h1234_5678;   9: return 32'h8000_FFFF;
      10: return 32'h0000_FFFF;  default: return 32'hA5A5_F00F;
    endcase
  endfunction

  function automatic string req_of(input logic [4:0] op);
    case (op)
      5'd0, 5'd2:            return "R2";
      5'd1, 5'd3:            return "R3";
      5'd4, 5'd5:            return "R4";
      5'd6, 5'd7, 5'd8, 5'd9: return "R5";
      5'd10:                 return "R6";
      5'd11, 5'd12:          return "R7";
      5'd13:                 return "R8";
      5'd14, 5'd15, 5'd16:   return "R9";
      default:               return "R10";
    endcase
  endfunction

  function automatic logic [32:0] model(input logic [4:0] op, input logic [31:0] a,
                                        input logic [31:0] b, input logic [4:0] sh);
    logic [31:0] r;
    logic        t;
    r = '0; t = 1'b0;
    case (op)
      5'd0: begin r = a + b; t = (a[31] == b[31]) && (r[31] != a[31]); end
      5'd1: r = a + b;
      5'd2: begin r = a - b; t = (a[31] != b[31]) && (r[31] != a[31]); end
      5'd3: r = a - b;
      5'd4: r = ($signed(a) < $signed(b)) ? 32'd1 : 32'd0;
      5'd5: r = (a < b) ? 32'd1 : 32'd0;
      5'd6: r = a & b;
      5'd7: r = a | b;
      5'd8: r = a ^ b;
      5'd9: r = ~(a | b);
      5'd10: r = {b[15:0], 16'h0000};
      5'd11: r = b << sh;
      5'd12: r = b >> sh;
      5'd13: r = $signed(b) >>> sh;
      5'd14: r = b << a[4:0];
      5'd15: r = b >> a[4:0];
      5'd16: r = $signed(b) >>> a[4:0];
      default: r = '0;
    endcase
    return {t, r};
  endfunction

  logic [32:0] last_exp = '0;

  task automatic apply(input logic [4:0] op, input logic [31:0] a,
                       input logic [31:0] b, input logic [4:0] sh);
    logic [32:0] e;
    @(negedge clk);
    op_i = op; a_i = a; b_i = b; shamt_i = sh;
    e = model(op, a, b, sh);
    #1;
    vectors++;
    // R11: outputs hold the previous result until the next edge
    if ({trap_o, result_o} !== last_exp) begin
      errors++;
      $display("FAIL R11 hold op=%0d got %h/%b exp %h/%b", op, result_o, trap_o,
               last_exp[31:0], last_exp[32]);
    end
    @(negedge clk);
    vectors++;
    if ({trap_o, result_o} !== e) begin
      errors++;
      $display("FAIL %s op=%0d a=%h b=%h sh=%0d got %h/%b exp %h/%b", req_of(op), op, a, b, sh,
               result_o, trap_o, e[31:0], e[32]);
    end
    last_exp = e;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired");
    $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    vectors++;
    // R1: reset state
    if (result_o !== 32'h0 || trap_o !== 1'b0) begin
      errors++;
      $display("FAIL R1 reset got %h/%b exp 00000000/0", result_o, trap_o);
    end
    rst = 1'b0;
    // R8: worked example, -5 arithmetic right by 1 is -3
    apply(5'd13, 32'h0, 32'hFFFF_FFFB, 5'd1);
    // R9: upper bits of A and the fixed count must not matter
    apply(5'd14, 32'hFFFF_FFE3, 32'h0000_0001, 5'd7);
    apply(5'd16, 32'h8000_0021, 32'h8000_0000, 5'd9);
    for (int op = 0; op < 32; op++)
      for (int ia = 0; ia < 12; ia++)
        for (int ib = 0; ib < 12; ib++)
          apply(5'(op), pat(ia), pat(ib), 5'((ia * 7 + ib * 3 + op) % 32));
    // R1: reset clears a non-zero result
    apply(5'd6, 32'hFFFF_FFFF, 32'hFFFF_FFFF, 5'd0);
    @(negedge clk);
    rst = 1'b1;
    @(negedge clk);
    vectors++;
    if (result_o !== 32'h0 || trap_o !== 1'b0) begin
      errors++;
      $display("FAIL R1 reset-after-use got %h/%b exp 00000000/0", result_o, trap_o);
    end
    $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
    $finish;
  end
endmodule